// File: doc/BRIEF.md
# Count-to-Limit Interval Timer

This block is a small register-mapped timer that sits in a processor's auxiliary register space. It holds a free-running count, a programmable limit and a control word. While its run bit is set the count steps up by one on every clock; when the count equals the limit it returns to zero on the next clock, and if interrupts are enabled it latches a pending flag that drives a level interrupt.

Software reaches the three registers through a plain register bus: an address, a write strobe, write data and combinational read data. A single write to the control word both acknowledges an interrupt and picks the next behaviour. Writing run plus interrupt-enable re-arms the timer for periodic ticks. Writing run alone leaves it counting silently, which is the one-shot case. Software can also reload the count, typically to zero, to start a fresh interval of `limit + 1` clocks.

Top module: `tick_timer`

## Requirements
- R1: After reset the count, the limit and the control word all read zero and the interrupt output is low.
- R2: The count increases by exactly one per clock while control bit 1 (run) is 1, and holds its value while that bit is 0.
- R3: When run is 1 and the count equals the limit, the count is zero on the next clock, so a full interval lasts limit + 1 clocks; a limit of zero keeps the count at zero.
- R4: Control bit 3 (pending) becomes 1 on the clock where the count wraps at the limit while control bit 0 (interrupt enable) is 1; it never becomes 1 while bit 0 is 0, and it stays 1 until the next control write.
- R5: The interrupt output is high exactly when pending and interrupt enable are both 1.
- R6: A control write stores only write-data bits 0 and 1 into enable and run, always clears pending (even on a clock where the count wraps), and control bits 2 and above 3 read as zero.
- R7: A write to the count register loads the written value on that clock, taking priority over both the increment and the wrap to zero.
- R8: With the limit at the all-ones value and interrupt enable at 0, the count passes through every value, rolls over from all-ones to zero and keeps going with no interrupt.
- R9: Register addresses are 0 for count, 1 for limit, 2 for control; address 3 reads zero and writes to it change nothing; read data follows the address in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | ADDR_W | Register select |
| regWe | input | 1 | Write strobe for the selected register |
| regWdata | input | DATA_W | Write data |
| regRdata | output | DATA_W | Read data of the selected register |
| timerIrq | output | 1 | Level interrupt request |

## Verification
The bench sweeps several small limits, including zero, and checks the count on every clock over more than two intervals; a design that wrapped one clock early or late, or that stalled at a zero limit, would drift from the arithmetic expectation. It writes the control word on the very clock the count wraps, where a design that let the wrap set pending over the write would leave the interrupt raised after an acknowledge. It also loads the count on a wrap clock, where a design that gave the wrap priority would read zero instead of the loaded value. A full roll-over at the all-ones limit catches a design that saturates or raises an interrupt without enable, and a control write with every bit set catches one that stores pending or reserved bits from software.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  // register map (address decoded by the control block)
  localparam int ADDR_COUNT = 0;
  localparam int ADDR_LIMIT = 1;
  localparam int ADDR_CTRL  = 2;

  // control word bit positions
  localparam int BIT_IE   = 0;
  localparam int BIT_RUN  = 1;
  localparam int BIT_PEND = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic cntLoad;   // software loads the count
    logic limLoad;   // software loads the limit
    logic advance;   // count steps this clock
    logic wrap;      // count reached the limit while running
  } tmrStrobe_t;

endpackage

// File: rtl/tick_timer_ctrl.sv
module tick_timer_ctrl
  import tick_timer_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [1:0]        wrBits,
  input  logic              atLimit,
  output tmrStrobe_t        strb,
  output logic              ieQ,
  output logic              runQ,
  output logic              pendQ
);

  logic ctrlLoad;

  always_comb begin
    ctrlLoad      = regWe && (regAddr == ADDR_W'(ADDR_CTRL));
    strb.cntLoad  = regWe && (regAddr == ADDR_W'(ADDR_COUNT));
    strb.limLoad  = regWe && (regAddr == ADDR_W'(ADDR_LIMIT));
    strb.advance  = runQ;
    strb.wrap     = runQ && atLimit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ieQ   <= 1'b0;
      runQ  <= 1'b0;
      pendQ <= 1'b0;
    end else begin
      if (ctrlLoad) begin
        ieQ   <= wrBits[BIT_IE];
        runQ  <= wrBits[BIT_RUN];
        pendQ <= 1'b0;            // write acknowledges, wins over a wrap
      end else if (strb.wrap && ieQ) begin
        pendQ <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/tick_timer_dp.sv
module tick_timer_dp
  import tick_timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobe_t        strb,
  input  logic [DATA_W-1:0] regWdata,
  output logic              atLimit,
  output logic [DATA_W-1:0] countQ,
  output logic [DATA_W-1:0] limitQ
);

  assign atLimit = (countQ == limitQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (strb.cntLoad) begin
      countQ <= regWdata;
    end else if (strb.wrap) begin
      countQ <= '0;
    end else if (strb.advance) begin
      countQ <= countQ + DATA_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      limitQ <= '0;
    end else if (strb.limLoad) begin
      limitQ <= regWdata;
    end
  end

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              timerIrq
);

  tmrStrobe_t        strb;
  logic              atLimit;
  logic [DATA_W-1:0] countQ;
  logic [DATA_W-1:0] limitQ;
  logic              ieQ;
  logic              runQ;
  logic              pendQ;
  logic [DATA_W-1:0] ctrlWord;

  tick_timer_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regAddr (regAddr),
    .regWe   (regWe),
    .wrBits  (regWdata[1:0]),
    .atLimit (atLimit),
    .strb    (strb),
    .ieQ     (ieQ),
    .runQ    (runQ),
    .pendQ   (pendQ)
  );

  tick_timer_dp #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .regWdata (regWdata),
    .atLimit  (atLimit),
    .countQ   (countQ),
    .limitQ   (limitQ)
  );

  always_comb begin
    ctrlWord           = '0;
    ctrlWord[BIT_IE]   = ieQ;
    ctrlWord[BIT_RUN]  = runQ;
    ctrlWord[BIT_PEND] = pendQ;
  end

  always_comb begin
    if (regAddr == ADDR_W'(ADDR_COUNT))      regRdata = countQ;
    else if (regAddr == ADDR_W'(ADDR_LIMIT)) regRdata = limitQ;
    else if (regAddr == ADDR_W'(ADDR_CTRL))  regRdata = ctrlWord;
    else                                     regRdata = '0;
  end

  assign timerIrq = pendQ & ieQ;

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
  import tick_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWe,
  input logic [DATA_W-1:0] regWdata,
  input logic              timerIrq,
  input logic [DATA_W-1:0] countQ,
  input logic [DATA_W-1:0] limitQ,
  input logic              ieQ,
  input logic              runQ,
  input logic              pendQ
);

  logic cntWr;
  logic ctlWr;
  assign cntWr = regWe && (regAddr == ADDR_W'(ADDR_COUNT));
  assign ctlWr = regWe && (regAddr == ADDR_W'(ADDR_CTRL));

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!runQ && !cntWr) |=> $stable(countQ)); // R2

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (runQ && countQ != limitQ && !cntWr) |=> countQ == $past(countQ) + DATA_W'(1)); // R2

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (runQ && countQ == limitQ && !cntWr) |=> countQ == '0); // R3

  AST_PEND_SET: assert property (@(posedge clk) disable iff (!rstN)
    (runQ && ieQ && countQ == limitQ && !ctlWr) |=> pendQ); // R4

  AST_NO_SPURIOUS_PEND: assert property (@(posedge clk) disable iff (!rstN)
    (!pendQ && !(runQ && ieQ && countQ == limitQ)) |=> !pendQ); // R4

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timerIrq) |-> ($past(countQ) == $past(limitQ) && $past(runQ))); // R5

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    ctlWr |=> (!pendQ && !timerIrq)); // R6

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rstN)
    cntWr |=> countQ == $past(regWdata)); // R7

endmodule

bind tick_timer tick_timer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regAddr  (regAddr),
  .regWe    (regWe),
  .regWdata (regWdata),
  .timerIrq (timerIrq),
  .countQ   (countQ),
  .limitQ   (limitQ),
  .ieQ      (ieQ),
  .runQ     (runQ),
  .pendQ    (pendQ)
);

// File: tb/sim_tick_timer.sv
`timescale 1ns/1ps
module sim_tick_timer;

  localparam int TW = 8;
  localparam int AW = 2;
  localparam logic [AW-1:0] A_CNT = 2'd0;
  localparam logic [AW-1:0] A_LIM = 2'd1;
  localparam logic [AW-1:0] A_CTL = 2'd2;
  localparam logic [AW-1:0] A_NONE = 2'd3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic          regWe = 1'b0;
  logic [TW-1:0] regWdata = '0;
  logic [TW-1:0] regRdata;
  logic          timerIrq;

  int  total = 0;
  int  bad = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  tick_timer #(.DATA_W(TW), .ADDR_W(AW)) u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .timerIrq(timerIrq)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // called at a negedge; returns at the next negedge, write captured in between
  task automatic wr(input logic [AW-1:0] a, input int d);
    regAddr  = a;
    regWdata = TW'(d);
    regWe    = 1'b1;
    @(negedge clk);
    regWe    = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output int v);
    regAddr = a;
    #1;
    v = int'(regRdata);
  endtask

  task automatic setup(input int lim, input int cnt, input int ctl);
    wr(A_CTL, 0);
    wr(A_CNT, cnt);
    wr(A_LIM, lim);
    wr(A_CTL, ctl);
  endtask

  initial begin
    int v;
    int c;
    int lims [6] = '{0, 1, 2, 3, 5, 7};
    int ieLims [3] = '{0, 2, 4};

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(A_CNT, v); chk("R1 count", v, 0);
    rd(A_LIM, v); chk("R1 limit", v, 0);
    rd(A_CTL, v); chk("R1 ctrl", v, 0);
    chk("R1 irq", int'(timerIrq), 0);

    // R2 halted count holds
    wr(A_LIM, 5);
    repeat (6) @(negedge clk);
    rd(A_CNT, v); chk("R2 halted", v, 0);

    // R3 / R2 interval sweep, run only
    foreach (lims[i]) begin
      setup(lims[i], 0, 2);
      for (int k = 0; k <= 2 * (lims[i] + 1) + 1; k++) begin
        rd(A_CNT, v); chk("R3 count", v, k % (lims[i] + 1));
        chk("R4 no irq without enable", int'(timerIrq), 0);
        @(negedge clk);
      end
    end

    // R4 / R5 pending with enable
    foreach (ieLims[i]) begin
      setup(ieLims[i], 0, 3);
      for (int k = 0; k <= 2 * (ieLims[i] + 1) + 1; k++) begin
        rd(A_CNT, v); chk("R3 count ie", v, k % (ieLims[i] + 1));
        chk("R5 irq", int'(timerIrq), (k >= ieLims[i] + 1) ? 1 : 0);
        rd(A_CTL, v); chk("R4 ctrl word", v, (k >= ieLims[i] + 1) ? 11 : 3);
        @(negedge clk);
      end
    end

    // R6 one-shot acknowledge: run only, pending cleared, no new irq
    wr(A_CTL, 2);
    chk("R6 ack irq", int'(timerIrq), 0);
    rd(A_CTL, v); chk("R6 ack ctrl", v, 2);
    repeat (12) @(negedge clk);
    chk("R6 one-shot stays quiet", int'(timerIrq), 0);

    // R6 periodic re-arm, limit 4
    rd(A_CNT, c);
    if (c == 4) begin
      @(negedge clk);
      c = 0;
    end
    wr(A_CTL, 3);
    for (int m = 0; m <= 4 - c; m++) begin
      chk("R6 rearm irq", int'(timerIrq), (m == 4 - c) ? 1 : 0);
      @(negedge clk);
    end

    // R6 control write on the wrap clock wins
    setup(3, 0, 3);
    repeat (3) @(negedge clk);
    rd(A_CNT, v); chk("R3 at limit", v, 3);
    wr(A_CTL, 3);
    chk("R6 write beats wrap irq", int'(timerIrq), 0);
    rd(A_CTL, v); chk("R6 write beats wrap ctrl", v, 3);
    rd(A_CNT, v); chk("R3 wrapped", v, 0);

    // R6 only bits 0,1 stored; reserved read zero
    wr(A_CTL, 255);
    rd(A_CTL, v); chk("R6 reserved bits", v, 3);

    // R7 count load while running, and on a wrap clock
    setup(200, 0, 2);
    wr(A_CNT, 50);
    rd(A_CNT, v); chk("R7 load", v, 50);
    @(negedge clk);
    rd(A_CNT, v); chk("R7 after load", v, 51);
    wr(A_CNT, 200);
    rd(A_CNT, v); chk("R7 load at limit", v, 200);
    wr(A_CNT, 7);
    rd(A_CNT, v); chk("R7 load beats wrap", v, 7);
    @(negedge clk);
    rd(A_CNT, v); chk("R7 continue", v, 8);

    // R8 full roll-over at all-ones limit
    setup(255, 253, 2);
    for (int k = 0; k < 6; k++) begin
      rd(A_CNT, v); chk("R8 rollover", v, (253 + k) % 256);
      chk("R8 no irq", int'(timerIrq), 0);
      @(negedge clk);
    end
    setup(255, 0, 2);
    for (int k = 0; k < 260; k++) begin
      rd(A_CNT, v); chk("R8 sweep", v, k % 256);
      @(negedge clk);
    end
    rd(A_CTL, v); chk("R8 no pending", v, 2);

    // R9 unused address
    setup(9, 4, 0);
    wr(A_NONE, 170);
    rd(A_NONE, v); chk("R9 unused reads zero", v, 0);
    rd(A_CNT, v); chk("R9 count untouched", v, 4);
    rd(A_LIM, v); chk("R9 limit untouched", v, 9);
    rd(A_CTL, v); chk("R9 ctrl untouched", v, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule